// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Access-Size Control

This block is a small synchronous data memory that a processor's load/store stage can attach to directly. The caller presents a 32-bit byte address, 32 bits of write data and an enable. A 2-bit operation code picks the access: an aligned word load, a single-byte store, an aligned halfword store or an aligned word store. Internally the storage is a column of 32-bit words. Each word is split into four byte lanes, and each lane has its own write strobe. A narrow store therefore changes only the lanes it targets and leaves the rest of the word as it was.

Stores take effect on the rising clock edge. A load returns the addressed word combinationally in the same cycle. Only a parameterised number of words exists, so the address above the word offset wraps modulo that depth. An access that breaks its alignment rule raises an error output for that cycle, and the memory is not touched.

Top module: `byte_mem`

## Requirements
- R1: With `en`=1, `mem_op`=2'b00 and `addr[1:0]`=0, `rdata` shows the addressed word in the same cycle, with no clock edge needed.
- R2: `rdata` is all zeros whenever the access is not an enabled, aligned word load. This covers all three store codes, a misaligned load and `en`=0.
- R3: `mem_op`=2'b01 stores `wdata[7:0]` at any byte address, little-endian: `addr[1:0]`=k selects word bits 8k+7..8k. The other three bytes keep their old values, and `wdata[31:8]` is ignored.
- R4: `mem_op`=2'b10 with `addr[0]`=0 stores `wdata[15:0]` into word bits 15..0 when `addr[1]`=0, or into bits 31..16 when `addr[1]`=1. The other half keeps its old value.
- R5: `mem_op`=2'b11 with `addr[1:0]`=0 replaces the whole addressed word with `wdata`.
- R6: `misalign` is 1 in the same cycle in two cases: an enabled halfword store with `addr[0]`=1, or an enabled word load or word store with `addr[1:0]`≠0. Such an access changes no memory contents.
- R7: With `en`=0, no store happens, `misalign` is 0 and `rdata` is 0, whatever the other inputs are.
- R8: The word index is `addr[31:2]` modulo DEPTH. Addresses that differ only in the bits above that index reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on its rising edge |
| en | input | 1 | Access enable |
| mem_op | input | 2 | 00 word load, 01 byte store, 10 halfword store, 11 word store |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data, right-aligned for narrow stores |
| rdata | output | 32 | Load data, zero when no load is active |
| misalign | output | 1 | Alignment error for the current access |

## Verification
`rdata` and `misalign` are combinational, so the bench drives each access just after a falling edge and samples both outputs one nanosecond later, before the next rising edge. A store becomes visible only after the rising edge that follows it. The bench therefore follows every store with a word load in the next cycle and compares the result against a model word. That model word is updated with shift-and-mask arithmetic at the same edge. This means a store that was wrongly suppressed, or that spilled into the wrong lane, shows up exactly one cycle after it was issued.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_WORD  = 2'b00,
    OP_STORE_BYTE = 2'b01,
    OP_STORE_HALF = 2'b10,
    OP_STORE_WORD = 2'b11
  } mem_op_e;

  // Alignment rule per access size
  function automatic logic op_aligned(input mem_op_e op, input logic [1:0] off);
    case (op)
      OP_STORE_BYTE: op_aligned = 1'b1;
      OP_STORE_HALF: op_aligned = (off[0] == 1'b0);
      default:       op_aligned = (off == 2'b00);
    endcase
  endfunction

  // Byte-lane strobe for a store of the given size at the given offset
  function automatic logic [3:0] lane_mask(input mem_op_e op, input logic [1:0] off);
    case (op)
      OP_STORE_BYTE: lane_mask = 4'b0001 << off;
      OP_STORE_HALF: lane_mask = 4'b0011 << off;
      OP_STORE_WORD: lane_mask = 4'b1111;
      default:       lane_mask = 4'b0000;
    endcase
  endfunction

  // Replicate narrow store data onto every lane it may occupy
  function automatic logic [31:0] spread_data(input mem_op_e op, input logic [31:0] wd);
    case (op)
      OP_STORE_BYTE: spread_data = {4{wd[7:0]}};
      OP_STORE_HALF: spread_data = {2{wd[15:0]}};
      default:       spread_data = wd;
    endcase
  endfunction

  // Word index: byte address over four, wrapped at the implemented depth
  function automatic logic [29:0] word_slot(input logic [31:0] a, input int unsigned depth);
    word_slot = a[31:2] % 30'(depth);
  endfunction

endpackage

// File: rtl/bm_access_decode.sv
module bm_access_decode
  import bm_pkg::*;
(
  input  logic       en,
  input  mem_op_e    op,
  input  logic [1:0] off,
  output logic [3:0] wr_strobe,
  output logic       rd_fire,
  output logic       misalign
);

  logic legal;

  always_comb begin
    legal     = op_aligned(op, off);
    misalign  = en && !legal;
    rd_fire   = en && legal && (op == OP_LOAD_WORD);
    wr_strobe = (en && legal) ? lane_mask(op, off) : 4'b0000;
  end

  always_comb begin
    // R6
    misalign_no_write_chk: assert (!(misalign && (wr_strobe != 4'b0000)));
    // R7
    idle_quiet_chk: assert (en || (!misalign && !rd_fire && wr_strobe == 4'b0000));
    // R3
    byte_one_lane_chk: assert (!(en && op == OP_STORE_BYTE) || $countones(wr_strobe) == 1);
    // R4
    half_pair_chk: assert (!(wr_strobe != 4'b0000 && op == OP_STORE_HALF)
                           || wr_strobe == 4'b0011 || wr_strobe == 4'b1100);
  end

endmodule

// File: rtl/bm_lane_steer.sv
module bm_lane_steer
  import bm_pkg::*;
(
  input  mem_op_e     op,
  input  logic [31:0] wdata,
  output logic [31:0] lanes
);

  always_comb lanes = spread_data(op, wdata);

endmodule

// File: rtl/bm_word_store.sv
module bm_word_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES-1:0]   strobe,
  input  logic [8*LANES-1:0] wlanes,
  output logic [8*LANES-1:0] rword
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe[g]) cells[idx] <= wlanes[8*g +: 8];
    end

    assign rword[8*g +: 8] = cells[idx];
  end

endmodule

// File: rtl/byte_mem.sv
module byte_mem
  import bm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        en,
  input  logic [1:0]  mem_op,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        misalign
);

  mem_op_e          op;
  logic [3:0]       wr_strobe;
  logic             rd_fire;
  logic [31:0]      lanes;
  logic [31:0]      rword;
  logic [29:0]      slot;
  logic [IDX_W-1:0] idx;

  assign op   = mem_op_e'(mem_op);
  assign slot = word_slot(addr, DEPTH);
  assign idx  = slot[IDX_W-1:0];

  bm_access_decode u_dec (
    .en(en), .op(op), .off(addr[1:0]),
    .wr_strobe(wr_strobe), .rd_fire(rd_fire), .misalign(misalign)
  );

  bm_lane_steer u_steer (.op(op), .wdata(wdata), .lanes(lanes));

  bm_word_store #(.DEPTH(DEPTH), .LANES(4)) u_store (
    .clk(clk), .idx(idx), .strobe(wr_strobe), .wlanes(lanes), .rword(rword)
  );

  assign rdata = rd_fire ? rword : 32'h0;

  always_comb begin
    // R2
    rdata_gate_chk: assert (rd_fire || rdata == 32'h0);
    // R1
    load_no_strobe_chk: assert (!rd_fire || wr_strobe == 4'b0000);
  end

endmodule

// File: tb/byte_mem_test.sv
module byte_mem_test;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mem_op = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [DEPTH];

  always #10 clk = ~clk;

  byte_mem #(.DEPTH(DEPTH)) uut (
    .clk(clk), .en(en), .mem_op(mem_op), .addr(addr),
    .wdata(wdata), .rdata(rdata), .misalign(misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic e, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] wd, input string req);
    logic al;
    int i;
    int off;
    logic [31:0] m;
    @(negedge clk);
    en = e; mem_op = op; addr = a; wdata = wd;
    al = (op == 2'b01) ? 1'b1 : (op == 2'b10) ? (a[0] == 1'b0) : (a[1:0] == 2'b00);
    i = int'((a >> 2) % DEPTH);
    off = int'(a[1:0]);
    #1;
    check({req, " misalign"}, {31'b0, misalign}, {31'b0, e && !al});
    check({req, " rdata"}, rdata, (e && op == 2'b00 && al) ? mdl[i] : 32'h0);
    @(posedge clk);
    if (e && al) begin
      case (op)
        2'b01: begin
          m = 32'hFF << (8 * off);
          mdl[i] = (mdl[i] & ~m) | ((wd & 32'hFF) << (8 * off));
        end
        2'b10: begin
          m = 32'hFFFF << (8 * off);
          mdl[i] = (mdl[i] & ~m) | ((wd & 32'hFFFF) << (8 * off));
        end
        2'b11: mdl[i] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic read_back(input int w, input string req);
    do_op(1'b1, 2'b00, 32'(w * 4), 32'h0, req);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7 reset state: idle outputs
    #5;
    check("R7 idle rdata", rdata, 32'h0);
    check("R7 idle misalign", {31'b0, misalign}, 32'h0);

    // R5 fill every word, then R1 read each back
    for (int w = 0; w < DEPTH; w++)
      do_op(1'b1, 2'b11, 32'(w * 4), 32'hA500_0000 ^ (32'(w) * 32'h0103_0507), "R5 word fill");
    for (int w = 0; w < DEPTH; w++) read_back(w, "R1 word load");

    // R6 R2 misaligned loads
    for (int a = 0; a < 4 * DEPTH; a++)
      if (a % 4 != 0) do_op(1'b1, 2'b00, 32'(a), 32'h0, "R6 R2 misaligned load");

    // R3 byte stores at every address, junk upper data bits
    for (int a = 0; a < 4 * DEPTH; a++) begin
      do_op(1'b1, 2'b01, 32'(a), 32'hFFFF_FF00 | 32'((a * 37 + 11) % 256), "R3 byte store");
      read_back(a / 4, "R3 byte readback");
    end

    // R4 R6 halfword stores at every offset
    for (int a = 0; a < 4 * DEPTH; a++) begin
      do_op(1'b1, 2'b10, 32'(a), 32'hC3C3_0000 | 32'((a * 4099 + 7) % 65536), "R4 R6 half store");
      read_back(a / 4, "R4 R6 half readback");
    end

    // R5 R6 word stores at every offset
    for (int a = 0; a < 4 * DEPTH; a++) begin
      do_op(1'b1, 2'b11, 32'(a), 32'h1357_9BDF + 32'(a) * 32'h0101_0101, "R5 R6 word store");
      read_back(a / 4, "R5 R6 word readback");
    end

    // R7 disabled stores of all kinds
    for (int op = 1; op < 4; op++) begin
      do_op(1'b0, 2'(op), 32'h0000_0008, 32'hFFFF_FFFF, "R7 disabled store");
      read_back(2, "R7 disabled readback");
    end
    do_op(1'b0, 2'b00, 32'h0000_0004, 32'h0, "R7 disabled load");
    do_op(1'b0, 2'b10, 32'h0000_0005, 32'h0, "R7 disabled misaligned");

    // R8 aliasing through upper address bits
    do_op(1'b1, 2'b11, 32'h8000_0000 + 32'(4 * DEPTH) + 32'd12, 32'hCAFE_F00D, "R8 alias store");
    read_back(3, "R8 alias readback");
    do_op(1'b1, 2'b01, 32'h4000_0001 + 32'(8 * DEPTH), 32'h0000_0077, "R8 alias byte");
    read_back(0, "R8 alias byte readback");
    do_op(1'b1, 2'b00, 32'hFFFF_FFFC, 32'h0, "R8 alias load top");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule